// File: doc/BRIEF.md
# Prioritised External Interrupt Controller

This block collects a small set of level-sensitive interrupt lines and turns them into a single machine-level external interrupt request for one processor hart. Software sets a priority for each source, an enable for each source, and one global threshold, all through a simple register bus. A source raises the request only when it is pending, enabled, and its priority is strictly above the threshold.

Software services interrupts with a claim and complete exchange. A read of the claim register returns the identifier of the best qualifying source, or 0 when none qualifies. The same read clears that source's pending state. The source's line is then ignored until software writes the same identifier back to the same register. Sources are numbered from 1, so identifier 0 always means "nothing", and source k sits at bit k of the pending and enable words.

The register bus uses address, write data, write enable, read enable and read data. Writes take effect at the clock edge. Read data is registered and appears one cycle after the read enable.

Top module: `irq_hub`

## Requirements
- R1: After reset, every priority, the enable word, the pending word, the threshold and all in-flight flags are zero. `ext_irq_o` is low, and every register reads back 0.
- R2: The priority of source k (1..NSRC) is the 32-bit word at byte offset 4*k. Only the low 3 bits are stored and the upper bits read 0. Offset 0 and any unmapped address read 0, and writes to them change nothing.
- R3: The enable word is at offset 0x2000, with source k at bit k. Bit 0 and bits above NSRC are not stored and read 0. A disabled source never wins a claim.
- R4: The pending word is at offset 0x1000 and is read-only, with source k at bit k. A high level on line k sets bit k at the next clock edge if the source is neither pending nor in flight. Writes to this word have no effect.
- R5: The threshold is at offset 0x200000 and is 3 bits wide. A source qualifies only when it is pending, enabled, and its priority is strictly greater than the threshold.
- R6: A read at offset 0x200004 returns the qualifying source with the highest priority. Among equal priorities the lowest identifier wins. The read returns 0 when no source qualifies.
- R7: A claim read that returns a nonzero identifier clears that source's pending bit and marks it in flight. While it is in flight, its line is ignored.
- R8: Writing an in-flight identifier to offset 0x200004 ends its flight, and a still-high line sets pending again at the following edge. A write naming an identifier that is not in flight, including 0 or an identifier above NSRC, has no effect.
- R9: `ext_irq_o` is registered. In each cycle it shows whether any source qualified during the previous cycle, so it falls one cycle after the claim that removes the last qualifying source.
- R10: `bus_rdata_o` carries the addressed value in the cycle after `bus_re_i` is high, and is 0 in the cycle after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt lines; bit k-1 is source k, active high |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_wdata_i | input | DATA_W | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_re_i | input | 1 | Read enable; a read of the claim register has a side effect |
| bus_rdata_o | output | DATA_W | Registered read data |
| ext_irq_o | output | 1 | Machine external interrupt request to the hart |

## Verification
The assertions assume that a read and a write never share a cycle. They also assume that completion writes carry plain identifiers, with no stray upper bits set. The bench respects both: its bus tasks raise only one of `bus_we_i` or `bus_re_i` per access, with idle cycles in between. Interrupt lines change only on falling clock edges, so they are stable when the gateways sample them. The stimulus drives lines high while sources are in flight, writes completions for idle and out-of-range identifiers, and arranges equal priorities, so that blocking, ignored writes and tie-breaks all show at the ports.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

   localparam logic [31:0] OFF_PEND  = 32'h0000_1000;
   localparam logic [31:0] OFF_EN    = 32'h0000_2000;
   localparam logic [31:0] OFF_THR   = 32'h0020_0000;
   localparam logic [31:0] OFF_CLAIM = 32'h0020_0004;

   typedef enum logic [2:0] {
      RG_NONE,
      RG_PRIO,
      RG_PEND,
      RG_EN,
      RG_THR,
      RG_CLAIM
   } region_e;

   typedef struct packed {
      region_e    region;
      logic [7:0] id;
   } dec_t;

   // Map a byte address onto a register region; id is set for priority slots.
   function automatic dec_t decode(input logic [31:0] a, input int nsrc);
      dec_t d;
      d.region = RG_NONE;
      d.id     = '0;
      if (a == OFF_PEND)       d.region = RG_PEND;
      else if (a == OFF_EN)    d.region = RG_EN;
      else if (a == OFF_THR)   d.region = RG_THR;
      else if (a == OFF_CLAIM) d.region = RG_CLAIM;
      else if (a[1:0] == 2'b00 && a != 32'd0 && a < 32'(4 * (nsrc + 1))) begin
         d.region = RG_PRIO;
         d.id     = a[9:2];
      end
      return d;
   endfunction

endpackage

// File: rtl/irq_hub_gate.sv
// Per-source gateway: latches a level request once, then stays blocked
// from claim until completion.
module irq_hub_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   input  logic claim_i,
   input  logic complete_i,
   output logic pend_o,
   output logic infl_o
);

   logic pend_q;
   logic infl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         infl_q <= 1'b0;
      end else begin
         if (claim_i && pend_q) begin
            pend_q <= 1'b0;
            infl_q <= 1'b1;
         end else begin
            if (line_i && !pend_q && !infl_q) pend_q <= 1'b1;
            if (complete_i && infl_q)         infl_q <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
   assign infl_o = infl_q;

endmodule

// File: rtl/irq_hub_arb.sv
// Combinational arbiter: strict-greater compare keeps the lowest id on ties.
module irq_hub_arb #(
   parameter int NSRC   = 4,
   parameter int PRIO_W = 3,
   localparam int ID_W  = $clog2(NSRC + 1)
) (
   input  logic [NSRC:1]             pend_i,
   input  logic [NSRC:1]             en_i,
   input  logic [NSRC:1][PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         thr_i,
   output logic [ID_W-1:0]           win_id_o,
   output logic                      any_o
);

   logic [NSRC:1] qual;

   for (genvar k = 1; k <= NSRC; k++) begin : g_qual
      assign qual[k] = pend_i[k] && en_i[k] && (prio_i[k] > thr_i);
   end

   always_comb begin
      logic [PRIO_W-1:0] best_p;
      best_p   = '0;
      win_id_o = '0;
      for (int k = 1; k <= NSRC; k++) begin
         if (qual[k] && prio_i[k] > best_p) begin
            best_p   = prio_i[k];
            win_id_o = ID_W'(k);
         end
      end
   end

   assign any_o = |qual;

endmodule

// File: rtl/irq_hub.sv
module irq_hub
   import irq_hub_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int PRIO_W = 3,
   parameter int ADDR_W = 22,
   parameter int DATA_W = 32,
   localparam int ID_W  = $clog2(NSRC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   input  logic              bus_we_i,
   input  logic              bus_re_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              ext_irq_o
);

   if (NSRC < 1 || NSRC + 1 > DATA_W || NSRC > 31) begin : g_bad_nsrc
      $error("irq_hub: NSRC out of range");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_hub: PRIO_W out of range");
   end
   if (ADDR_W < 22 || ADDR_W > 32) begin : g_bad_addr
      $error("irq_hub: ADDR_W must cover the claim offset");
   end

   dec_t                      dec;
   logic                      claim_rd;
   logic                      claim_wr;
   logic [NSRC:1][PRIO_W-1:0] prio_q;
   logic [NSRC:1]             en_q;
   logic [PRIO_W-1:0]         thr_q;
   logic [NSRC:1]             pend_vec;
   logic [NSRC:1]             infl_vec;
   logic [ID_W-1:0]           win_id;
   logic                      any_qual;
   logic                      irq_q;
   logic [DATA_W-1:0]         rd_val;
   logic [DATA_W-1:0]         rdata_q;

   assign dec      = decode(32'(bus_addr_i), NSRC);
   assign claim_rd = bus_re_i && dec.region == RG_CLAIM;
   assign claim_wr = bus_we_i && dec.region == RG_CLAIM;

   // Gateways
   for (genvar k = 1; k <= NSRC; k++) begin : g_src
      logic hit_claim;
      logic hit_done;
      assign hit_claim = claim_rd && win_id == ID_W'(k);
      assign hit_done  = claim_wr && bus_wdata_i == DATA_W'(k);

      irq_hub_gate u_gate (
         .clk        (clk),
         .rst_n      (rst_n),
         .line_i     (src_i[k-1]),
         .claim_i    (hit_claim),
         .complete_i (hit_done),
         .pend_o     (pend_vec[k]),
         .infl_o     (infl_vec[k])
      );
   end

   irq_hub_arb #(
      .NSRC   (NSRC),
      .PRIO_W (PRIO_W)
   ) u_arb (
      .pend_i   (pend_vec),
      .en_i     (en_q),
      .prio_i   (prio_q),
      .thr_i    (thr_q),
      .win_id_o (win_id),
      .any_o    (any_qual)
   );

   // Configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
         en_q   <= '0;
         thr_q  <= '0;
      end else if (bus_we_i) begin
         unique case (dec.region)
            RG_PRIO: begin
               for (int k = 1; k <= NSRC; k++) begin
                  if (dec.id == 8'(k)) prio_q[k] <= bus_wdata_i[PRIO_W-1:0];
               end
            end
            RG_EN:   en_q  <= bus_wdata_i[NSRC:1];
            RG_THR:  thr_q <= bus_wdata_i[PRIO_W-1:0];
            default: ;
         endcase
      end
   end

   // Read mux
   always_comb begin
      rd_val = '0;
      unique case (dec.region)
         RG_PRIO: begin
            for (int k = 1; k <= NSRC; k++) begin
               if (dec.id == 8'(k)) rd_val[PRIO_W-1:0] = prio_q[k];
            end
         end
         RG_PEND:  rd_val[NSRC:1]   = pend_vec;
         RG_EN:    rd_val[NSRC:1]   = en_q;
         RG_THR:   rd_val[PRIO_W-1:0] = thr_q;
         RG_CLAIM: rd_val[ID_W-1:0] = win_id;
         default:  ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         rdata_q <= bus_re_i ? rd_val : '0;
         irq_q   <= any_qual;
      end
   end

   assign bus_rdata_o = rdata_q;
   assign ext_irq_o   = irq_q;

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk
   import irq_hub_pkg::*;
#(
   parameter int NSRC   = 4,
   parameter int ADDR_W = 22,
   parameter int DATA_W = 32,
   parameter int ID_W   = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [DATA_W-1:0] bus_wdata_i,
   input logic              bus_we_i,
   input logic              bus_re_i,
   input logic [DATA_W-1:0] bus_rdata_o,
   input logic              ext_irq_o,
   input logic [NSRC:1]     pend_vec,
   input logic [NSRC:1]     infl_vec,
   input logic [ID_W-1:0]   win_id
);

   logic          at_claim;
   logic [NSRC:0] win_full;
   logic [NSRC:1] win_mask;
   logic [NSRC:1] done_mask;

   assign at_claim = 32'(bus_addr_i) == OFF_CLAIM;
   assign win_full = (NSRC + 1)'(1) << win_id;
   assign win_mask = win_full[NSRC:1];

   for (genvar k = 1; k <= NSRC; k++) begin : g_mask
      assign done_mask[k] = bus_wdata_i == DATA_W'(k);
   end

   // R7: a source is never pending and in flight at once
   p_excl_pend_infl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_vec & infl_vec) == '0);

   // R7: a claim read drops the winner's pending bit
   p_claim_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re_i && at_claim && win_id != '0) |=> ((pend_vec & $past(win_mask)) == '0));

   // R8: completion of an in-flight id ends its flight
   p_complete_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && !bus_re_i && at_claim && (done_mask & infl_vec) != '0)
      |=> ((infl_vec & $past(done_mask)) == '0));

   // R9: the request only follows a cycle with something pending
   p_irq_needs_pend_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ext_irq_o |-> $past(pend_vec != '0));

   // R2: reserved offset 0 reads as zero
   p_slot0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_re_i && bus_addr_i == '0) |=> bus_rdata_o == '0);

   // R10: no read, no data
   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re_i |=> bus_rdata_o == '0);

endmodule

bind irq_hub irq_hub_chk #(
   .NSRC   (NSRC),
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .ID_W   (ID_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .bus_we_i    (bus_we_i),
   .bus_re_i    (bus_re_i),
   .bus_rdata_o (bus_rdata_o),
   .ext_irq_o   (ext_irq_o),
   .pend_vec    (pend_vec),
   .infl_vec    (infl_vec),
   .win_id      (win_id)
);

// File: tb/irq_hub_tb_top.sv
`timescale 1ns/1ps
module irq_hub_tb_top;

   localparam int NS = 4;
   localparam logic [21:0] A_PEND  = 22'h001000;
   localparam logic [21:0] A_EN    = 22'h002000;
   localparam logic [21:0] A_THR   = 22'h200000;
   localparam logic [21:0] A_CLAIM = 22'h200004;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  src = '0;
   logic [21:0] addr = '0;
   logic [31:0] wdata = '0;
   logic        we = 1'b0;
   logic        re = 1'b0;
   logic [31:0] rdata;
   logic        irq;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   string phase = "R1";

   always #4 clk = ~clk;

   irq_hub dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .src_i       (src),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_we_i    (we),
      .bus_re_i    (re),
      .bus_rdata_o (rdata),
      .ext_irq_o   (irq)
   );

   // Behavioural reference
   int m_prio[1:NS];
   int m_en, m_thr, m_irq, m_rd;
   bit m_pend[1:NS];
   bit m_infl[1:NS];

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 1; k <= NS; k++) begin
            m_prio[k] = 0; m_pend[k] = 0; m_infl[k] = 0;
         end
         m_en = 0; m_thr = 0; m_irq = 0; m_rd = 0;
      end else begin
         int best, bp, a;
         bit anyq;
         bit np[1:NS];
         bit ni[1:NS];
         best = 0; bp = 0; anyq = 0; a = int'(addr);
         for (int k = 1; k <= NS; k++) begin
            if (m_pend[k] && m_en[k] && m_prio[k] > m_thr) begin
               anyq = 1;
               if (m_prio[k] > bp) begin bp = m_prio[k]; best = k; end
            end
            np[k] = m_pend[k]; ni[k] = m_infl[k];
         end
         m_rd = 0;
         if (re) begin
            if (a >= 4 && a <= 4 * NS && a % 4 == 0) m_rd = m_prio[a / 4];
            else if (a == int'(A_PEND)) begin
               for (int k = 1; k <= NS; k++) if (m_pend[k]) m_rd = m_rd | (1 << k);
            end
            else if (a == int'(A_EN)) m_rd = m_en;
            else if (a == int'(A_THR)) m_rd = m_thr;
            else if (a == int'(A_CLAIM)) begin
               m_rd = best;
               if (best != 0) begin np[best] = 0; ni[best] = 1; end
            end
         end
         for (int k = 1; k <= NS; k++)
            if (src[k-1] && !m_pend[k] && !m_infl[k]) np[k] = 1;
         if (we) begin
            if (a >= 4 && a <= 4 * NS && a % 4 == 0) m_prio[a / 4] = int'(wdata) & 7;
            else if (a == int'(A_EN)) m_en = int'(wdata) & 32'h1E;
            else if (a == int'(A_THR)) m_thr = int'(wdata) & 7;
            else if (a == int'(A_CLAIM) && wdata >= 1 && wdata <= NS && m_infl[wdata])
               ni[wdata] = 0;
         end
         for (int k = 1; k <= NS; k++) begin m_pend[k] = np[k]; m_infl[k] = ni[k]; end
         m_irq = anyq ? 1 : 0;
      end
   end

   // Every-cycle comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_cmp++;
         if (int'(rdata) != m_rd || int'(irq) != m_irq) begin
            n_bad++;
            $display("FAIL %s cycle compare: rdata=%0h irq=%0d expected rdata=%0h irq=%0d",
                     phase, rdata, irq, m_rd, m_irq);
         end
      end
   end

   task automatic check(input string req, input int got, input int exp, input string what);
      n_cmp++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   task automatic wr(input logic [21:0] a, input logic [31:0] d);
      @(negedge clk); addr = a; wdata = d; we = 1'b1;
      @(negedge clk); we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [21:0] a, output int d);
      @(negedge clk); addr = a; re = 1'b1;
      @(negedge clk); re = 1'b0; d = int'(rdata);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      phase = "R1";
      check("R1", int'(irq), 0, "irq after reset");
      rd(22'h4, v);    check("R1", v, 0, "prio1 after reset");
      rd(A_EN, v);     check("R1", v, 0, "enable after reset");
      rd(A_PEND, v);   check("R1", v, 0, "pending after reset");
      rd(A_THR, v);    check("R1", v, 0, "threshold after reset");
      rd(A_CLAIM, v);  check("R1", v, 0, "claim after reset");

      // R2 priority slots and reserved addresses
      phase = "R2";
      wr(22'h4, 32'hFF);   rd(22'h4, v);   check("R2", v, 7, "prio1 width");
      wr(22'h0, 32'h5);    rd(22'h0, v);   check("R2", v, 0, "slot 0 reserved");
      wr(22'h100, 32'h7);  rd(22'h100, v); check("R2", v, 0, "unmapped address");

      // R3 enable word
      phase = "R3";
      wr(A_EN, 32'hFFFF_FFFF); rd(A_EN, v); check("R3", v, 32'h1E, "enable mask");

      // R4 pending latch, read-only
      phase = "R4";
      src[1] = 1'b1;
      idle(1);
      rd(A_PEND, v); check("R4", v, 32'h4, "pending after line 2");
      wr(A_PEND, 32'h0);
      rd(A_PEND, v); check("R4", v, 32'h4, "pending write ignored");

      // R5 threshold masking
      phase = "R5";
      wr(22'h4, 2); wr(22'h8, 2); wr(22'hC, 5); wr(22'h10, 3);
      wr(A_THR, 2);
      idle(2);
      check("R5", int'(irq), 0, "prio equal to threshold masked");

      // R9 registered request
      phase = "R9";
      wr(A_THR, 1);
      check("R9", int'(irq), 0, "irq one cycle after threshold write");
      idle(1);
      check("R9", int'(irq), 1, "irq two cycles after threshold write");

      // R6 arbitration order and tie-break
      phase = "R6";
      src = 4'hF;
      idle(2);
      rd(A_CLAIM, v); check("R6", v, 3, "highest priority first");
      rd(A_CLAIM, v); check("R6", v, 4, "second priority");
      rd(A_CLAIM, v); check("R6", v, 1, "tie goes to lowest id");
      rd(A_CLAIM, v); check("R6", v, 2, "last source");
      rd(A_CLAIM, v); check("R6", v, 0, "none left");

      // R7 in-flight sources ignore their lines
      phase = "R7";
      idle(2);
      rd(A_PEND, v); check("R7", v, 0, "lines high but all in flight");
      check("R7", int'(irq), 0, "irq low with all claimed");

      // R8 completion
      phase = "R8";
      wr(A_CLAIM, 9); wr(A_CLAIM, 0);
      rd(A_PEND, v); check("R8", v, 0, "bad completion ids ignored");
      wr(A_CLAIM, 4);
      idle(1);
      rd(A_PEND, v); check("R8", v, 32'h10, "completion re-arms source 4");
      wr(A_CLAIM, 4);
      rd(A_PEND, v); check("R8", v, 32'h10, "repeat completion ignored");
      rd(A_CLAIM, v); check("R8", v, 4, "re-armed source claimed");

      // R5 threshold against a pending source
      phase = "R5";
      wr(A_CLAIM, 3);
      idle(1);
      wr(A_THR, 5);
      rd(A_CLAIM, v); check("R5", v, 0, "prio 5 at threshold 5 masked");
      wr(A_THR, 4);
      rd(A_CLAIM, v); check("R5", v, 3, "prio 5 above threshold 4");

      // R3 disabled source never wins
      phase = "R3";
      wr(A_CLAIM, 1);
      wr(A_THR, 0);
      wr(A_EN, 32'h1C);
      rd(A_CLAIM, v); check("R3", v, 0, "disabled source not claimed");
      wr(A_EN, 32'h1E);
      rd(A_CLAIM, v); check("R3", v, 1, "re-enabled source claimed");

      // R10 idle read data and wind-down
      phase = "R10";
      src = '0;
      wr(A_CLAIM, 1); wr(A_CLAIM, 2); wr(A_CLAIM, 3); wr(A_CLAIM, 4);
      idle(2);
      check("R10", int'(rdata), 0, "rdata zero without read");
      rd(A_PEND, v); check("R10", v, 0, "nothing pending after wind-down");
      check("R9", int'(irq), 0, "irq low at end");

      done = 1;
      summary();
      $finish;
   end

endmodule